// File: doc/BRIEF.md
# Exception Status Flag Capture Unit

This block records diagnostic status at the moment a general exception is taken. On the cycle an exception-taken strobe is high, it decodes a 4-bit cause code and updates three status flags: one that marks a bad-address condition, one that marks a permission violation, and one that says whether the fault came from a data access. It also loads a faulting-address register with either the instruction byte address or the data byte address, depending on which side of the pipeline caused the fault.

Between exceptions every value holds. Software can overwrite the flags and the address register through a direct write port while no exception is being taken. A break exception is signalled on its own input. It leaves the data-access flag as it was, while the other flags follow the cause code.

Top module: `exc_flag_capture`

## Requirements
- R1: On a taken exception, `badFlag` becomes 1 for cause codes 1 (privileged instruction fetch), 2 (privileged data access), 3 (misaligned data access) and 4 (misaligned branch target). It becomes 0 for every other code, including the unrecognised codes 0 and 11 to 15.
- R2: On a taken exception, `permFlag` becomes 1 for codes 7 (translation permission fault on a read or write) and 8 (translation permission fault on an execute). It becomes 0 for every other code.
- R3: On a taken exception that is not a break, `dataFlag` becomes 1 for codes 2, 3, 5 (fast data translation miss), 6 (double data translation miss) and 7. It becomes 0 for every other code.
- R4: On a taken exception with `excBreak` high, `dataFlag` keeps its previous value, while `badFlag` and `permFlag` follow R1 and R2.
- R5: On a taken exception, `faultAddr` loads `insnAddr` for codes 1, 4, 8, 9 (fast instruction translation miss) and 10 (double instruction translation miss). It loads `dataAddr` for codes 2, 3, 5, 6 and 7. For all other codes it keeps its value.
- R6: When neither `excTaken` nor `swWrEn` is high, all flags and `faultAddr` hold. Every update appears one clock after the sampling edge.
- R7: Synchronous reset (`rst` high at a clock edge) clears all three flags and `faultAddr` to zero.
- R8: With `swWrEn` high and `excTaken` low, the flags and `faultAddr` take `swBad`, `swPerm`, `swData` and `swAddr`.
- R9: When `excTaken` and `swWrEn` are high in the same cycle, the exception update applies and the software write is discarded in full, including the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| excTaken | input | 1 | General exception taken this cycle |
| excCause | input | 4 | Exception cause code |
| excBreak | input | 1 | Exception is a break |
| insnAddr | input | ADDR_W | Faulting instruction byte address |
| dataAddr | input | ADDR_W | Faulting data byte address |
| swWrEn | input | 1 | Software write strobe |
| swBad | input | 1 | Software value for bad-address flag |
| swPerm | input | 1 | Software value for permission flag |
| swData | input | 1 | Software value for data-access flag |
| swAddr | input | ADDR_W | Software value for faulting address |
| badFlag | output | 1 | Bad-address flag |
| permFlag | output | 1 | Permission flag |
| dataFlag | output | 1 | Data-access flag |
| faultAddr | output | ADDR_W | Captured faulting address |

## Verification
The hardest case to reach is a break exception that arrives while the data-access flag is already set. A non-break data fault must set the flag first, and only then can a break show that the flag survives it. The vector table places a data-side fault directly before a break and then places an unrecognised non-break code after it, so the flag is seen to hold and then to clear. The collision of a software write with an exception is driven in one cycle with a cause that keeps the address. That way a leaked software address would show at the port.

// File: rtl/exc_flag_pkg.sv
package exc_flag_pkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_OTHER     = 4'd0,
    CAUSE_PRIV_INSN = 4'd1,
    CAUSE_PRIV_DATA = 4'd2,
    CAUSE_MIS_DATA  = 4'd3,
    CAUSE_MIS_DEST  = 4'd4,
    CAUSE_FMISS_D   = 4'd5,
    CAUSE_DMISS_D   = 4'd6,
    CAUSE_PERM_RW   = 4'd7,
    CAUSE_PERM_X    = 4'd8,
    CAUSE_FMISS_I   = 4'd9,
    CAUSE_DMISS_I   = 4'd10
  } cause_e;

  typedef struct packed {
    logic loadFlags;
    logic loadData;
    logic setBad;
    logic setPerm;
    logic setData;
    logic loadAddr;
    logic pickData;
    logic swLoad;
  } ctrl_t;
endpackage

// File: rtl/exc_flag_ctrl.sv
module exc_flag_ctrl
  import exc_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               excTaken,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               excBreak,
  input  logic               swWrEn,
  output ctrl_t              ctrl
);
  logic isBad, isPerm, isData, isInsnSide, isDataSide;

  always_comb begin
    isBad = 1'b0;
    isPerm = 1'b0;
    isData = 1'b0;
    isInsnSide = 1'b0;
    isDataSide = 1'b0;
    case (excCause)
      CAUSE_PRIV_INSN: begin isBad = 1'b1; isInsnSide = 1'b1; end
      CAUSE_PRIV_DATA: begin isBad = 1'b1; isData = 1'b1; isDataSide = 1'b1; end
      CAUSE_MIS_DATA:  begin isBad = 1'b1; isData = 1'b1; isDataSide = 1'b1; end
      CAUSE_MIS_DEST:  begin isBad = 1'b1; isInsnSide = 1'b1; end
      CAUSE_FMISS_D:   begin isData = 1'b1; isDataSide = 1'b1; end
      CAUSE_DMISS_D:   begin isData = 1'b1; isDataSide = 1'b1; end
      CAUSE_PERM_RW:   begin isPerm = 1'b1; isData = 1'b1; isDataSide = 1'b1; end
      CAUSE_PERM_X:    begin isPerm = 1'b1; isInsnSide = 1'b1; end
      CAUSE_FMISS_I:   isInsnSide = 1'b1;
      CAUSE_DMISS_I:   isInsnSide = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    ctrl.loadFlags = excTaken;
    ctrl.loadData  = excTaken && !excBreak;
    ctrl.setBad    = isBad;
    ctrl.setPerm   = isPerm;
    ctrl.setData   = isData;
    ctrl.loadAddr  = excTaken && (isInsnSide || isDataSide);
    ctrl.pickData  = isDataSide;
    ctrl.swLoad    = swWrEn && !excTaken;
  end

  // R9
  ctrl_precedence_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadFlags |-> !ctrl.swLoad);

  // R2
  ctrl_perm_not_bad_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.setPerm |-> !ctrl.setBad);
endmodule

// File: rtl/exc_flag_dp.sv
module exc_flag_dp
  import exc_flag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] insnAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              swBad,
  input  logic              swPerm,
  input  logic              swData,
  input  logic [ADDR_W-1:0] swAddr,
  output logic              badFlag,
  output logic              permFlag,
  output logic              dataFlag,
  output logic [ADDR_W-1:0] faultAddr
);
  logic [ADDR_W-1:0] capAddr;

  assign capAddr = ctrl.pickData ? dataAddr : insnAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      badFlag   <= 1'b0;
      permFlag  <= 1'b0;
      dataFlag  <= 1'b0;
      faultAddr <= '0;
    end else if (ctrl.loadFlags) begin
      badFlag  <= ctrl.setBad;
      permFlag <= ctrl.setPerm;
      if (ctrl.loadData) dataFlag <= ctrl.setData;
      if (ctrl.loadAddr) faultAddr <= capAddr;
    end else if (ctrl.swLoad) begin
      badFlag   <= swBad;
      permFlag  <= swPerm;
      dataFlag  <= swData;
      faultAddr <= swAddr;
    end
  end

  // R6
  dp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.loadFlags || ctrl.swLoad) |=>
      ($stable(badFlag) && $stable(permFlag) && $stable(dataFlag) && $stable(faultAddr)));

  // R4
  dp_break_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.loadFlags && !ctrl.loadData) |=> $stable(dataFlag));

  // R5
  dp_addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.loadFlags && !ctrl.loadAddr) |=> $stable(faultAddr));

  // R7
  dp_reset_chk: assert property (@(posedge clk)
    rst |=> (!badFlag && !permFlag && !dataFlag && faultAddr == '0));
endmodule

// File: rtl/exc_flag_capture.sv
module exc_flag_capture
  import exc_flag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excTaken,
  input  logic [3:0]        excCause,
  input  logic              excBreak,
  input  logic [ADDR_W-1:0] insnAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              swWrEn,
  input  logic              swBad,
  input  logic              swPerm,
  input  logic              swData,
  input  logic [ADDR_W-1:0] swAddr,
  output logic              badFlag,
  output logic              permFlag,
  output logic              dataFlag,
  output logic [ADDR_W-1:0] faultAddr
);
  ctrl_t ctrl;

  exc_flag_ctrl i_ctrl (
    .clk(clk), .rst(rst), .excTaken(excTaken), .excCause(excCause),
    .excBreak(excBreak), .swWrEn(swWrEn), .ctrl(ctrl)
  );

  exc_flag_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .insnAddr(insnAddr), .dataAddr(dataAddr),
    .swBad(swBad), .swPerm(swPerm), .swData(swData), .swAddr(swAddr),
    .badFlag(badFlag), .permFlag(permFlag), .dataFlag(dataFlag), .faultAddr(faultAddr)
  );
endmodule

// File: tb/test_exc_flag_capture.sv
`timescale 1ns/1ps
module test_exc_flag_capture;
  localparam int AW = 32;
  localparam int NV = 17;
  // vector fields: cause[9:6], break[5], bad[4], perm[3], data[2], addrKind[1:0] (0 keep, 1 insn, 2 data)
  localparam logic [9:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2},
    {4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    {4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
    {4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},
    {4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    {4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2},
    {4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic excTaken = 1'b0, excBreak = 1'b0, swWrEn = 1'b0;
  logic [3:0] excCause = '0;
  logic swBad = 1'b0, swPerm = 1'b0, swData = 1'b0;
  logic [AW-1:0] insnAddr = '0, dataAddr = '0, swAddr = '0;
  logic badFlag, permFlag, dataFlag;
  logic [AW-1:0] faultAddr;

  int checks = 0, failures = 0;
  logic mBad = 1'b0, mPerm = 1'b0, mData = 1'b0;
  logic [AW-1:0] mAddr = '0;

  always #4 clk = ~clk;

  exc_flag_capture #(.ADDR_W(AW)) i_exc_flag_capture (
    .clk(clk), .rst(rst), .excTaken(excTaken), .excCause(excCause), .excBreak(excBreak),
    .insnAddr(insnAddr), .dataAddr(dataAddr), .swWrEn(swWrEn), .swBad(swBad),
    .swPerm(swPerm), .swData(swData), .swAddr(swAddr), .badFlag(badFlag),
    .permFlag(permFlag), .dataFlag(dataFlag), .faultAddr(faultAddr)
  );

  task automatic check(input string req);
    checks++;
    if (badFlag !== mBad || permFlag !== mPerm || dataFlag !== mData || faultAddr !== mAddr) begin
      failures++;
      $display("FAIL %s: got bad=%b perm=%b data=%b addr=%h expected bad=%b perm=%b data=%b addr=%h",
               req, badFlag, permFlag, dataFlag, faultAddr, mBad, mPerm, mData, mAddr);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 reset state");

    // vector walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      excCause = VEC[i][9:6];
      excBreak = VEC[i][5];
      insnAddr = 32'h1000_0000 + 32'(i) * 32'h10;
      dataAddr = 32'h2000_0003 + 32'(i) * 32'h8;
      excTaken = 1'b1;
      @(negedge clk);
      excTaken = 1'b0;
      mBad = VEC[i][4];
      mPerm = VEC[i][3];
      if (!VEC[i][5]) mData = VEC[i][2];
      if (VEC[i][1:0] == 2'd1) mAddr = insnAddr;
      else if (VEC[i][1:0] == 2'd2) mAddr = dataAddr;
      check($sformatf("R1/R2/R3/R4/R5 vector %0d cause %0d", i, VEC[i][9:6]));
    end

    // R6: inputs change without strobe
    excCause = 4'd2; insnAddr = 32'hDEAD_0000; dataAddr = 32'hBEEF_0000;
    repeat (3) @(negedge clk);
    check("R6 hold without strobe");

    // R8: software write while idle
    swWrEn = 1'b1; swBad = 1'b1; swPerm = 1'b1; swData = 1'b1; swAddr = 32'hCAFE_1234;
    @(negedge clk);
    swWrEn = 1'b0;
    mBad = 1'b1; mPerm = 1'b1; mData = 1'b1; mAddr = 32'hCAFE_1234;
    check("R8 software write");

    // R4: break keeps data flag set by software
    excTaken = 1'b1; excBreak = 1'b1; excCause = 4'd0;
    @(negedge clk);
    excTaken = 1'b0; excBreak = 1'b0;
    mBad = 1'b0; mPerm = 1'b0;
    check("R4 break keeps data flag");

    // R9: collision, cause 0 keeps addr, sw write discarded
    swWrEn = 1'b1; swBad = 1'b1; swPerm = 1'b1; swData = 1'b0; swAddr = 32'h5555_AAAA;
    excTaken = 1'b1; excCause = 4'd0;
    @(negedge clk);
    excTaken = 1'b0; swWrEn = 1'b0;
    mBad = 1'b0; mPerm = 1'b0; mData = 1'b0;
    check("R9 exception beats software write");

    // R9: collision with address capture
    swWrEn = 1'b1; swAddr = 32'h7777_0000; swBad = 1'b0;
    excTaken = 1'b1; excCause = 4'd4; insnAddr = 32'h0000_0102;
    @(negedge clk);
    excTaken = 1'b0; swWrEn = 1'b0;
    mBad = 1'b1; mAddr = 32'h0000_0102;
    check("R9 exception address beats software write");

    // R7: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mBad = 1'b0; mPerm = 1'b0; mData = 1'b0; mAddr = '0;
    check("R7 reset clears captured state");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule